// File: doc/BRIEF.md
# Sequenced Shift-and-Add Multiply Step Unit

This block forms a full product by repeating one conditional add-and-shift step. Each step takes the running partial product and shifts it right by one bit. The true sign of the previous sum (negative flag XOR overflow flag) enters the top bit. The multiplicand is then added only when bit 0 of the multiplier register is set. The bit shifted out of the partial product moves into the top of the multiplier register as that register shifts right. Each step also updates a four-bit flag set using the normal addition rules.

A small state machine drives the step unit. A start pulse in the idle state does four things: it clears the partial product and the flags, loads the multiplier, and captures the multiplicand. The multiplicand comes either from a full-width input or from a sign-extended 13-bit immediate. The machine then runs `W` steps and one last step with a zero multiplicand. After that the high word of the product sits in `prod_hi_o` and the low word in `prod_lo_o`. The partial state is visible on the ports during the run, so each step can be checked cycle by cycle.

States: `ST_IDLE` waits for start. `ST_STEP` performs the `W` multiplicand steps. `ST_FINAL` performs the zero-multiplicand step. Transitions:
- idle to step on start.
- step to step while the step count is below `W-1`.
- step to final on the last count.
- final to idle unconditionally, raising done.

Top module: `mstep_mul_top`

## Requirements
- R1: After reset, `prod_hi_o`, `prod_lo_o` and `flags_o` are zero and `busy_o` and `done_o` are low.
- R2: When `start_i` is high and the unit is idle at a clock edge, the next cycle shows `busy_o` high, `prod_hi_o` zero, `flags_o` zero and `prod_lo_o` equal to the sampled `mplier_i`.
- R3: The multiplicand captured at start is `mcand_i` when `use_imm_i` is 0, and `imm_i` sign-extended from bit 12 to `W` bits when `use_imm_i` is 1.
- R4: In each step the addend taken from the partial product is the partial product shifted right by one, with (flag N XOR flag V) placed in bit `W-1`.
- R5: The multiplicand is added only when bit 0 of the multiplier register is 1; otherwise zero is added. The new partial product is the `W`-bit sum.
- R6: In each step the multiplier register shifts right by one, and the old bit 0 of the partial product enters its bit `W-1`.
- R7: `flags_o` is {N,Z,V,C} in bits 3..0. N is sum bit `W-1`, Z is set when the sum is zero, V is signed overflow of the add, and C is the carry out of the add.
- R8: A run is exactly `W` steps using the captured multiplicand, followed by one step using a zero multiplicand.
- R9: `done_o` is a one-cycle pulse. It rises 33 clock edges after the edge that accepted start (for `W`=32), in the same cycle that `busy_o` falls.
- R10: When `done_o` is high, {`prod_hi_o`,`prod_lo_o`} equals the captured multiplicand taken as signed times the loaded multiplier taken as unsigned, as a 2`W`-bit value.
- R11: `start_i` while `busy_o` is high has no effect on the run or its result.
- R12: While idle with no start, `prod_hi_o`, `prod_lo_o` and `flags_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a multiply when idle |
| use_imm_i | input | 1 | Select the immediate as multiplicand |
| mcand_i | input | W | Full-width multiplicand |
| imm_i | input | IMM_W | Signed immediate multiplicand |
| mplier_i | input | W | Multiplier (unsigned) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | W | Partial product / product high word |
| prod_lo_o | output | W | Multiplier register / product low word |
| flags_o | output | 4 | Flags {N,Z,V,C} of the last step |

## Verification
The bench builds the block with `W`=32 and `IMM_W`=13. At these values the sign extension of a 13-bit immediate into a 32-bit multiplicand can be exercised. The most negative 32-bit multiplicand combined with an all-ones multiplier drives the partial-product add into signed overflow on most steps, which is what makes the N XOR V sign recovery matter. The 32-step run length also gives the 33-cycle completion point stated in the requirements.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_FINAL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mstep_alu.sv
module mstep_alu
    import mstep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mier_i,
    input  cc_t          cc_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] mier_o,
    output cc_t          cc_o
);
    logic [W-1:0] shifted;
    logic [W-1:0] gated;
    logic         carry;

    always_comb begin
        // sign recovered from the previous sum goes into the top bit
        shifted        = {cc_i.n ^ cc_i.v, part_i[W-1:1]};
        gated          = mier_i[0] ? mcand_i : '0;
        {carry, sum_o} = {1'b0, shifted} + {1'b0, gated};
        cc_o.n         = sum_o[W-1];
        cc_o.z         = (sum_o == '0);
        cc_o.v         = (shifted[W-1] == gated[W-1]) && (sum_o[W-1] != shifted[W-1]);
        cc_o.c         = carry;
        mier_o         = {part_i[0], mier_i[W-1:1]};
    end
endmodule

// File: rtl/mstep_opsel.sv
module mstep_opsel #(
    parameter int W     = 32,
    parameter int IMM_W = 13
) (
    input  logic             use_imm_i,
    input  logic [W-1:0]     reg_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [W-1:0]     op_o
);
    logic [W-1:0] imm_ext;

    generate
        if (W > IMM_W) begin : g_extend
            assign imm_ext = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[W-1:0];
        end
    endgenerate

    assign op_o = use_imm_i ? imm_ext : reg_i;
endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
    import mstep_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic final_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FINAL);
            if (state_q == ST_STEP) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_STEP;
            ST_STEP:  if (cnt_q == LAST) state_d = ST_FINAL;
            ST_FINAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        step_o  = (state_q == ST_STEP);
        final_o = (state_q == ST_FINAL);
        busy_o  = (state_q != ST_IDLE);
        done_o  = done_q;
    end
endmodule

// File: rtl/mstep_mul_top.sv
module mstep_mul_top
    import mstep_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             use_imm_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [W-1:0]     mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     prod_hi_o,
    output logic [W-1:0]     prod_lo_o,
    output logic [3:0]       flags_o
);
    logic         load, step, fin;
    logic [W-1:0] part_q, mier_q, mc_q;
    cc_t          cc_q;
    logic [W-1:0] op_sel, sum, mier_nx, step_mc;
    cc_t          cc_nx;

    mstep_seq #(.STEPS(W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .step_o(step), .final_o(fin),
        .busy_o(busy_o), .done_o(done_o)
    );

    mstep_opsel #(.W(W), .IMM_W(IMM_W)) opsel_i (
        .use_imm_i(use_imm_i), .reg_i(mcand_i), .imm_i(imm_i), .op_o(op_sel)
    );

    assign step_mc = fin ? '0 : mc_q;

    mstep_alu #(.W(W)) alu_i (
        .part_i(part_q), .mcand_i(step_mc), .mier_i(mier_q), .cc_i(cc_q),
        .sum_o(sum), .mier_o(mier_nx), .cc_o(cc_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            mier_q <= '0;
            mc_q   <= '0;
            cc_q   <= '0;
        end else if (load) begin
            part_q <= '0;
            mier_q <= mplier_i;
            mc_q   <= op_sel;
            cc_q   <= '0;
        end else if (step || fin) begin
            part_q <= sum;
            mier_q <= mier_nx;
            cc_q   <= cc_nx;
        end
    end

    assign prod_hi_o = part_q;
    assign prod_lo_o = mier_q;
    assign flags_o   = cc_q;
endmodule

// File: rtl/mstep_mul_chk.sv
module mstep_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] mplier_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] prod_hi_o,
    input logic [W-1:0] prod_lo_o,
    input logic [3:0]   flags_o
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && prod_hi_o == '0 && flags_o == 4'd0
                                  && prod_lo_o == $past(mplier_i))); // R2

    AST_MIER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (prod_lo_o[W-2:0] == $past(prod_lo_o[W-1:1])
                    && prod_lo_o[W-1] == $past(prod_hi_o[0]))); // R6

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> (flags_o[2] == (prod_hi_o == '0)
                           && flags_o[3] == prod_hi_o[W-1])); // R7

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)
                                   && $stable(flags_o))); // R12
endmodule

bind mstep_mul_top mstep_mul_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .prod_hi_o(prod_hi_o),
    .prod_lo_o(prod_lo_o), .flags_o(flags_o)
);

// File: tb/mstep_mul_tb_top.sv
`timescale 1ns/1ps
module mstep_mul_tb_top;
    localparam int W = 32;
    localparam int IMM_W = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic use_imm = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [IMM_W-1:0] imm = '0;
    logic [W-1:0] mplier = '0;
    logic busy, done;
    logic [W-1:0] hi, lo;
    logic [3:0] flags;

    always #2 clk = ~clk;

    mstep_mul_top #(.W(W), .IMM_W(IMM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .use_imm_i(use_imm),
        .mcand_i(mcand), .imm_i(imm), .mplier_i(mplier),
        .busy_o(busy), .done_o(done), .prod_hi_o(hi), .prod_lo_o(lo),
        .flags_o(flags)
    );

    int n_vec = 0;
    int n_bad = 0;
    int n_cyc = 0;

    // reference model state
    int          m_st = 0;
    int          m_cnt = 0;
    logic [31:0] m_p = 0, m_y = 0, m_mc = 0, m_y0 = 0;
    logic [3:0]  m_cc = 0;
    logic        m_done = 0;

    function automatic void do_step(input logic [31:0] mcv);
        logic [31:0] a, b, s;
        longint t;
        a = {m_cc[3] ^ m_cc[1], m_p[31:1]};           // R4
        b = m_y[0] ? mcv : 32'd0;                      // R5
        t = longint'({32'd0, a}) + longint'({32'd0, b});
        s = t[31:0];
        m_cc = {s[31], s == 32'd0, (a[31] == b[31]) && (s[31] != a[31]), t[32]}; // R7
        m_y = {m_p[0], m_y[31:1]};                     // R6
        m_p = s;
    endfunction

    function automatic void check(input string req, input string what,
                                  input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        n_cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_p = 0; m_y = 0; m_mc = 0; m_cc = 0; m_done = 0;
        end else if (m_st == 0) begin
            m_done = 0;
            if (start) begin                           // R2, R3
                m_p = 0; m_cc = 0; m_y = mplier; m_y0 = mplier;
                m_mc = use_imm ? {{(W-IMM_W){imm[IMM_W-1]}}, imm} : mcand;
                m_st = 1; m_cnt = 0;
            end
        end else if (m_st == 1) begin                  // R8, R11
            do_step(m_mc);
            m_cnt++;
            if (m_cnt == W) m_st = 2;
        end else begin
            do_step(32'd0);
            m_st = 0; m_done = 1;
        end
        @(negedge clk);
        check("R1/R4/R5", "prod_hi", longint'(hi), longint'(m_p));
        check("R6", "prod_lo", longint'(lo), longint'(m_y));
        check("R7", "flags", longint'(flags), longint'(m_cc));
        check("R9", "busy", longint'(busy), longint'(m_st != 0));
        check("R9", "done", longint'(done), longint'(m_done));
        if (m_done) begin                              // R10
            longint prod;
            prod = longint'($signed(m_mc)) * longint'({32'd0, m_y0});
            check("R10", "product", longint'({hi, lo}), prod);
        end
    endtask

    task automatic run_mul(input logic [31:0] mc, input logic [31:0] y,
                           input logic ui, input logic [IMM_W-1:0] im, input bit poke);
        start = 1; mcand = mc; mplier = y; use_imm = ui; imm = im;
        tick();
        start = 0;
        for (int i = 0; i < 40 && !m_done; i++) begin
            if (poke && i == 10) begin                 // R11: start while busy
                start = 1; mcand = 32'h1234_5678; mplier = 32'hFFFF_0000; use_imm = 0;
            end else begin
                start = 0;
            end
            tick();
        end
        start = 0;
        check("R9", "done seen", longint'(m_done), 1);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();                                        // R1 reset state
        check("R1", "reset hi", longint'(hi), 0);
        check("R1", "reset flags", longint'(flags), 0);
        repeat (3) tick();                             // R12 idle hold
        run_mul(32'd0, 32'd0, 0, '0, 0);
        run_mul(32'd1, 32'd1, 0, '0, 0);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, '0, 0);
        run_mul(32'h8000_0000, 32'hFFFF_FFFF, 0, '0, 0);
        run_mul(32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, '0, 0);
        run_mul(32'h8000_0000, 32'h8000_0001, 0, '0, 0);
        run_mul(32'hDEAD_BEEF, 32'h0BAD_F00D, 0, '0, 1);   // R11
        run_mul(32'h0, 32'd12345, 1, 13'h1000, 0);         // R3 most negative imm
        run_mul(32'h0, 32'hFFFF_FFFF, 1, 13'h0FFF, 0);     // R3 largest imm
        run_mul(32'hFFFF_FFFF, 32'd777, 1, 13'h1FFF, 0);   // R3 imm -1 ignores mcand
        // back-to-back: start in the done cycle
        run_mul(32'd3, 32'd5, 0, '0, 0);
        run_mul(32'hFFFF_FFF9, 32'd6, 0, '0, 0);
        for (int k = 0; k < 20; k++)
            run_mul($urandom, $urandom, 1'($urandom), 13'($urandom), 0);
        repeat (4) tick();                             // R12 hold after run
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule